// File: doc/BRIEF.md
# PWM Timer Channel with Doze Suspension

This block is one pulse-width modulation channel with a small 16-bit register interface. Software sets a period and a duty width and enables counting. The counter then advances on each pulse of an external tick enable and returns to zero once it has matched the period. The output pin is at its active level while the count is below the width. A polarity bit can invert that level. Each period match sets a sticky interrupt flag, and the flag can drive an interrupt line.

The system also supplies a doze indication. A control bit chooses between two behaviours. In one, the channel ignores doze. In the other, the channel keeps running until the current period completes and then holds itself at count zero with the output inactive. The interrupt for that final period match is still raised, so it can wake the processor. When doze is released, the channel starts a fresh period from zero without any register rewrites. New period and width values are held in shadow registers and are applied only at a period boundary, so no glitched cycle is produced.

Top module: `pwm_doze_chan`

## Requirements
- R1: After reset, all four registers read 0, `pwm_out` is 0 and `irq` is 0.
- R2: Control bit 0 enables counting. While it is set and the channel is not suspended, the counter increments by one on each clock edge where `tick_en` is 1 and holds otherwise. While it is clear, the counter returns to 0 and stays there.
- R3: With period value P, the counter steps through 0..P and goes from P back to 0 on the next tick, so a period lasts P+1 ticks. That wrap sets the interrupt flag, which is control bit 3.
- R4: While the channel runs, `pwm_out` equals (counter < W) XOR control bit 1, where W is the active width. While it is stopped or suspended, `pwm_out` equals control bit 1.
- R5: The flag stays set until a control write with bit 3 equal to 1 clears it. A write with bit 3 equal to 0 leaves it set. `irq` is the flag AND control bit 2.
- R6: Register selector 1 is the period and selector 2 is the width. A write to either reads back at once. While the channel runs, the new value takes effect only at the next wrap. While it is stopped, the new value takes effect immediately.
- R7: With control bit 4 clear, `doze_i` has no effect on counting.
- R8: With control bit 4 set, asserting `doze_i` lets the current period finish. The wrap at P still sets the flag. After that, the counter holds at 0 and sets no further flag while doze lasts.
- R9: When `doze_i` falls, a suspended channel clears its suspension on the next edge and then counts up from 0 on the following ticks. The registers keep their values.
- R10: Control bits 15..5 read as 0 and ignore writes. Writes to selector 3, which reads the counter, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count tick enable, one clock wide per tick |
| doze_i | input | 1 | System doze indication |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select (byte offset / 2): 0 control, 1 period, 2 width, 3 counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_sel`, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Interrupt request |

## Verification
A register write lands on the clock edge that samples `bus_we`, and its readback is due at the following falling edge. A tick moves the counter on the edge that samples it. `pwm_out` and `irq` follow the counter and the flag in the same cycle, because they are decoded from registered state with no extra stage. Entering suspension therefore shows at the falling edge after the wrap edge. Leaving it takes one edge to clear and one more ticked edge before the count reaches 1. The bench drives inputs and samples outputs on falling edges only. For every sweep step it computes the count as k mod (P+1), counted from the enabling edge, and derives the output level from that count.

// File: rtl/pwm_doze_pkg.sv
`timescale 1ns/1ps
package pwm_doze_pkg;
  // control register image, bit 0 at the bottom of the struct
  typedef struct packed {
    logic dstop;  // bit 4: stop at period end while doze is active
    logic flag;   // bit 3: period-match flag, write 1 to clear
    logic ien;    // bit 2: interrupt enable
    logic pol;    // bit 1: output polarity
    logic cen;    // bit 0: count enable
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int FLAG_BIT = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PER  = 2'd1;
  localparam logic [1:0] SEL_WID  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_doze_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          wrap,
  input  logic [DW-1:0] cnt,
  output ctrl_t         ctrl_q,
  output logic [DW-1:0] per_act_q,
  output logic [DW-1:0] wid_act_q,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PAD_W = DW - CTRL_W;

  ctrl_t         ctrl_d;
  ctrl_t         wr_ctrl;
  logic [DW-1:0] per_sh_q, per_sh_d;
  logic [DW-1:0] wid_sh_q, wid_sh_d;
  logic          load_act;

  assign wr_ctrl = ctrl_t'(wdata[CTRL_W-1:0]);

  // next-state
  always_comb begin
    ctrl_d   = ctrl_q;
    per_sh_d = per_sh_q;
    wid_sh_d = wid_sh_q;
    if (we && sel == SEL_CTRL) begin
      ctrl_d.cen   = wr_ctrl.cen;
      ctrl_d.pol   = wr_ctrl.pol;
      ctrl_d.ien   = wr_ctrl.ien;
      ctrl_d.dstop = wr_ctrl.dstop;
      if (wr_ctrl.flag) ctrl_d.flag = 1'b0;
    end
    if (wrap) ctrl_d.flag = 1'b1;  // set wins over clear
    if (we && sel == SEL_PER) per_sh_d = wdata;
    if (we && sel == SEL_WID) wid_sh_d = wdata;
  end

  // active compare values follow the shadows only at a boundary or when idle
  assign load_act = wrap || !ctrl_q.cen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      per_sh_q  <= '0;
      wid_sh_q  <= '0;
      per_act_q <= '0;
      wid_act_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      per_sh_q <= per_sh_d;
      wid_sh_q <= wid_sh_d;
      if (load_act) begin
        per_act_q <= per_sh_d;
        wid_act_q <= wid_sh_d;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata = {{PAD_W{1'b0}}, ctrl_q};
      SEL_PER:  rdata = per_sh_q;
      SEL_WID:  rdata = wid_sh_q;
      default:  rdata = cnt;
    endcase
  end

  assign irq = ctrl_q.flag & ctrl_q.ien;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ctrl_q.flag); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flag && !(we && sel == SEL_CTRL && wdata[FLAG_BIT])) |=> ctrl_q.flag); // R5
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.cen && !wrap) |=> ($stable(per_act_q) && $stable(wid_act_q))); // R6
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cen,
  input  logic          doze_req,
  input  logic [DW-1:0] per,
  output logic [DW-1:0] cnt_q,
  output logic          wrap,
  output logic          running
);
  logic [DW-1:0] cnt_d;
  logic          susp_q, susp_d;
  logic          hit;

  assign running = cen && !susp_q;
  assign hit     = (cnt_q == per);
  assign wrap    = running && tick && hit;

  always_comb begin
    cnt_d = cnt_q;
    if (!running)  cnt_d = '0;
    else if (tick) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  // suspension is entered only on a wrap and lasts while doze is requested
  assign susp_d = doze_req && (susp_q || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      susp_q <= susp_d;
    end
  end

  AST_CEN_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> (cnt_q == '0)); // R2
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick) |=> $stable(cnt_q)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per); // R3
  AST_DOZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !doze_req |=> !susp_q); // R7
  AST_SUSP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> ((cnt_q == '0) && $past(wrap))); // R8
  AST_RESUME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_q) |-> (cnt_q == '0)); // R9
endmodule

// File: rtl/pwm_outgen.sv
`timescale 1ns/1ps
module pwm_outgen #(
  parameter int DW = 16
) (
  input  logic          running,
  input  logic          pol,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] wid,
  output logic          pwm_out
);
  logic active;

  assign active  = running && (cnt < wid);
  assign pwm_out = pol ^ active;
endmodule

// File: rtl/pwm_doze_chan.sv
`timescale 1ns/1ps
module pwm_doze_chan
  import pwm_doze_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          doze_i,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out,
  output logic          irq
);
  logic [1:0]    rst_pipe;
  logic          rst_n_s;
  ctrl_t         ctrl;
  logic [DW-1:0] per_act, wid_act, cnt;
  logic          wrap, running;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  pwm_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .we        (bus_we),
    .sel       (bus_sel),
    .wdata     (bus_wdata),
    .wrap      (wrap),
    .cnt       (cnt),
    .ctrl_q    (ctrl),
    .per_act_q (per_act),
    .wid_act_q (wid_act),
    .rdata     (bus_rdata),
    .irq       (irq)
  );

  pwm_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (tick_en),
    .cen      (ctrl.cen),
    .doze_req (doze_i && ctrl.dstop),
    .per      (per_act),
    .cnt_q    (cnt),
    .wrap     (wrap),
    .running  (running)
  );

  pwm_outgen #(.DW(DW)) u_out (
    .running (running),
    .pol     (ctrl.pol),
    .cnt     (cnt),
    .wid     (wid_act),
    .pwm_out (pwm_out)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> ($past(wrap) || $past(bus_we && bus_sel == SEL_CTRL))); // R5
endmodule

// File: tb/pwm_doze_chan_test.sv
`timescale 1ns/1ps
module pwm_doze_chan_test;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        doze_i;
  logic        bus_we;
  logic [1:0]  bus_sel;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        pwm_out;
  logic        irq;

  int checks;
  int fails;
  bit finished;

  pwm_doze_chan uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .doze_i    (doze_i),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    bus_we  = 1'b0;
    bus_sel = s;
    #0.1;
    v = int'(bus_rdata);
  endtask

  task automatic wr(input logic [1:0] s, input int v);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_sel   = s;
    bus_wdata = 16'(v);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    checks = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; doze_i = 1'b0;
    bus_we = 1'b0; bus_sel = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 register after reset", v, 0);
    end
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 irq after reset", int'(irq), 0);

    // R3/R4 sweep over period, width and polarity
    for (int p = 0; p < 6; p++) begin
      for (int w = 0; w < 8; w++) begin
        for (int pl = 0; pl < 2; pl++) begin
          tick_en = 1'b0;
          wr(2'd0, (pl << 1) | 8);
          wr(2'd1, p);
          wr(2'd2, w);
          chk("R4 stopped level", int'(pwm_out), pl);
          tick_en = 1'b1;
          wr(2'd0, 1 | (pl << 1));
          for (int k = 0; k < 2 * p + 3; k++) begin
            rd(2'd3, v);
            chk("R3 counter sequence", v, k % (p + 1));
            chk("R4 output level", int'(pwm_out), pl ^ int'((k % (p + 1)) < w));
            @(negedge clk);
          end
          rd(2'd0, v);
          chk("R3 flag after wrap", (v >> 3) & 1, 1);
        end
      end
    end
    tick_en = 1'b0;
    wr(2'd0, 8);

    // R2 gapped ticks, then disable
    begin
      int e;
      e = 0;
      wr(2'd1, 9);
      wr(2'd0, 1);
      for (int i = 0; i < 20; i++) begin
        tick_en = (i % 3 != 0);
        @(negedge clk);
        if (i % 3 != 0) e = (e + 1) % 10;
        rd(2'd3, v);
        chk("R2 gapped counting", v, e);
      end
      tick_en = 1'b0;
      wr(2'd0, 0);
      @(negedge clk);
      rd(2'd3, v);
      chk("R2 cleared when disabled", v, 0);
    end

    // R5 flag and interrupt
    wr(2'd0, 8);
    wr(2'd1, 3);
    wr(2'd2, 1);
    wr(2'd0, 1 | 4);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    chk("R5 irq on wrap", int'(irq), 1);
    wr(2'd0, 1 | 4);
    chk("R5 flag kept by write of 0", int'(irq), 1);
    wr(2'd0, 1);
    chk("R5 irq masked", int'(irq), 0);
    rd(2'd0, v);
    chk("R5 flag still set", v, 16'h0009);
    wr(2'd0, 1 | 4 | 8);
    chk("R5 irq after clear", int'(irq), 0);
    rd(2'd0, v);
    chk("R5 flag cleared", v, 16'h0005);
    wr(2'd0, 8);

    // R6 period/width update at boundary
    wr(2'd1, 7);
    wr(2'd2, 2);
    tick_en = 1'b1;
    wr(2'd0, 1);
    for (int k = 0; k < 20; k++) begin
      int ec, ew;
      ec = (k < 8) ? k : (k - 8) % 4;
      ew = (k < 8) ? 2 : 1;
      rd(2'd3, v);
      chk("R6 counter across update", v, ec);
      chk("R6 output across update", int'(pwm_out), int'(ec < ew));
      if (k == 4) begin
        rd(2'd1, v);
        chk("R6 period readback", v, 3);
      end
      if (k == 2) begin bus_we = 1'b1; bus_sel = 2'd1; bus_wdata = 16'd3; end
      if (k == 3) begin bus_we = 1'b1; bus_sel = 2'd2; bus_wdata = 16'd1; end
      @(negedge clk);
      bus_we = 1'b0;
    end
    tick_en = 1'b0;
    wr(2'd0, 8);

    // R7 doze ignored with stop bit clear
    wr(2'd1, 4);
    wr(2'd2, 2);
    doze_i  = 1'b1;
    tick_en = 1'b1;
    wr(2'd0, 1 | 4);
    for (int k = 0; k < 15; k++) begin
      rd(2'd3, v);
      chk("R7 doze ignored", v, k % 5);
      @(negedge clk);
    end
    tick_en = 1'b0;
    doze_i  = 1'b0;
    wr(2'd0, 8);

    // R8 suspension at period end, R9 resume
    tick_en = 1'b1;
    wr(2'd0, 1 | 4 | 16);
    for (int k = 0; k < 11; k++) begin
      int ec;
      ec = (k < 5) ? k : 0;
      rd(2'd3, v);
      chk("R8 finish period then hold", v, ec);
      chk("R8 output", int'(pwm_out), int'(k < 5 && ec < 2));
      chk("R8 final irq", int'(irq), int'(k >= 5));
      if (k == 2) doze_i = 1'b1;
      @(negedge clk);
    end
    wr(2'd0, 1 | 4 | 16 | 8);
    chk("R8 no further flag", int'(irq), 0);
    rd(2'd3, v);
    chk("R8 held at zero", v, 0);
    doze_i = 1'b0;
    for (int j = 1; j < 9; j++) begin
      @(negedge clk);
      rd(2'd3, v);
      chk("R9 resume from zero", v, (j - 1) % 5);
      chk("R9 output on resume", int'(pwm_out), int'(((j - 1) % 5) < 2));
    end
    rd(2'd1, v);
    chk("R9 period kept", v, 4);
    tick_en = 1'b0;
    wr(2'd0, 8);

    // R10 unused bits and counter write
    wr(2'd0, 16'hFFF6);
    rd(2'd0, v);
    chk("R10 unused control bits", v, 16'h0016);
    wr(2'd0, 0);
    wr(2'd1, 20);
    wr(2'd0, 1);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    wr(2'd3, 16'h00AB);
    rd(2'd3, v);
    chk("R10 counter write ignored", v, 3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule